// File: doc/BRIEF.md
# Dual-Lane Rotate-Mask Interpolator

The block has two lanes. Each lane holds a 32-bit accumulator, a 32-bit base and a control word. A lane takes an accumulator as its source, either its own or the other lane's. It rotates that source right and keeps a programmable, inclusive bit window. It can sign-extend the window from its top bit. It then adds the base to form the lane result. A third result, the combined sum, adds both bases to lane 0's extracted window.

A processor reaches the block through a plain register port. It can write accumulators, bases and control words, and read them back. It can inspect results without side effects (peek) or consume them (pop). A pop reloads both accumulators with the lane results, which makes the block step through a sequence. Bus reads of lane results can OR a 2-bit pattern into the upper address bits, which is useful for generating pointers into memory regions.

Top module: `interp_dual`

## Requirements
- R1: After reset, every accumulator, base and control word is zero, and every readable address returns 0.
- R2: A write to ACC0 (0), ACC1 (1), BASE0 (2), BASE1 (3), CTRL0 (4) or CTRL1 (5) is visible on a read from the next cycle. A control word stores bits 20:0 only and reads back zero-extended. Control layout: rotate amount [4:0], window low bit [9:5], window high bit [14:10], sign-extend [15], cross-input [16], cross-result [17], raw-add [18], force pattern [20:19].
- R3: A lane rotates its source right by the rotate amount, then keeps bits low..high inclusive and zeroes all others.
- R4: When the window high bit is below the low bit, the window is empty and yields zero.
- R5: With sign-extend set, every bit above the window high bit copies the window's top bit. The lane result and the lane's peek and pop reads use this extended value.
- R6: With cross-input set, the other lane's accumulator is the lane source. This also holds when raw-add is set.
- R7: With raw-add set, the lane result is base plus the unrotated, unmasked source. The combined result ignores raw-add.
- R8: The combined result (peek address 8, pop address 11) equals BASE0 + BASE1 + lane 0's extracted window, where that window follows lane 0's cross-input and sign-extend settings.
- R9: Lane peek and pop reads (6/9 for lane 0, 7/10 for lane 1) OR the force pattern into bits 29:28. Accumulator writeback and the combined result never carry it.
- R10: Reading a peek address (6, 7, 8) leaves both accumulators unchanged.
- R11: A read of any pop address (9, 10, 11) loads both accumulators at the next edge, from results computed on the values held before that edge. With cross-result set, a lane takes the other lane's result instead of its own. A same-cycle write to an accumulator takes priority over its pop reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 to 5) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pop addresses act only while it is high |
| rd_addr | input | 4 | Read address (0 to 11) |
| rd_data | output | 32 | Read data, combinational; 0 when rd_en is low or the address is unused |

## Verification
Read data is combinational, so a peek or pop result is due in the same cycle as its rd_en. Register writes and pop reloads show up on reads from the following cycle. The bench drives each access at the falling edge and samples rd_data 1 ns later, before the rising edge. It updates its model only at the rising edge that commits the access, so every expected value comes from the state held before that edge.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int DATA_W  = 32;
  localparam int SH_W    = $clog2(DATA_W);
  localparam int FORCE_W = 2;
  localparam int ADDR_W  = 4;

  typedef struct packed {
    logic [FORCE_W-1:0] force_hi;
    logic               add_raw;
    logic               cross_result;
    logic               cross_input;
    logic               is_signed;
    logic [SH_W-1:0]    win_hi;
    logic [SH_W-1:0]    win_lo;
    logic [SH_W-1:0]    rot;
  } lane_ctrl_t;

  localparam int CTRL_W = $bits(lane_ctrl_t);

  localparam logic [ADDR_W-1:0] A_ACC0  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ACC1  = 4'd1;
  localparam logic [ADDR_W-1:0] A_BASE0 = 4'd2;
  localparam logic [ADDR_W-1:0] A_BASE1 = 4'd3;
  localparam logic [ADDR_W-1:0] A_CTRL0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 4'd5;
  localparam logic [ADDR_W-1:0] A_PEEK0 = 4'd6;
  localparam logic [ADDR_W-1:0] A_PEEK1 = 4'd7;
  localparam logic [ADDR_W-1:0] A_PEEKF = 4'd8;
  localparam logic [ADDR_W-1:0] A_POP0  = 4'd9;
  localparam logic [ADDR_W-1:0] A_POP1  = 4'd10;
  localparam logic [ADDR_W-1:0] A_POPF  = 4'd11;
endpackage

// File: rtl/interp_extract.sv
module interp_extract
  import interp_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  lane_ctrl_t        ctrl,
  output logic [DATA_W-1:0] window
);
  logic [2*DATA_W-1:0] twice;
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   upto_hi;
  logic [DATA_W-1:0]   from_lo;
  logic [DATA_W-1:0]   keep;
  logic [DATA_W-1:0]   kept;
  logic                top_bit;

  always_comb begin
    // right rotate via a doubled word
    twice   = {src, src} >> ctrl.rot;
    rotated = twice[DATA_W-1:0];
    upto_hi = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(ctrl.win_hi));
    from_lo = {DATA_W{1'b1}} << ctrl.win_lo;
    keep    = (ctrl.win_hi >= ctrl.win_lo) ? (upto_hi & from_lo) : '0;
    kept    = rotated & keep;
    top_bit = kept[ctrl.win_hi];
    window  = kept | ((ctrl.is_signed && top_bit) ? ~upto_hi : '0);
  end
endmodule

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
(
  input  logic [DATA_W-1:0] acc_own,
  input  logic [DATA_W-1:0] acc_other,
  input  logic [DATA_W-1:0] base,
  input  lane_ctrl_t        ctrl,
  output logic [DATA_W-1:0] window,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] src;

  // source select sits ahead of the raw-add bypass
  assign src = ctrl.cross_input ? acc_other : acc_own;

  interp_extract u_extract (
    .src    (src),
    .ctrl   (ctrl),
    .window (window)
  );

  assign result = base + (ctrl.add_raw ? src : window);
endmodule

// File: rtl/interp_dual.sv
module interp_dual
  import interp_pkg::*;
#(
  parameter int FORCE_POS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LANES = 2;

  logic [DATA_W-1:0] acc_q   [LANES];
  logic [DATA_W-1:0] base_q  [LANES];
  lane_ctrl_t        ctrl_q  [LANES];
  logic [DATA_W-1:0] lane_win[LANES];
  logic [DATA_W-1:0] lane_res[LANES];
  logic [DATA_W-1:0] bus_res [LANES];
  logic [DATA_W-1:0] full_res;
  logic              pop_fire;

  assign pop_fire = rd_en &&
                    (rd_addr == A_POP0 || rd_addr == A_POP1 || rd_addr == A_POPF);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] reload;

    interp_lane u_lane (
      .acc_own   (acc_q[g]),
      .acc_other (acc_q[1-g]),
      .base      (base_q[g]),
      .ctrl      (ctrl_q[g]),
      .window    (lane_win[g]),
      .result    (lane_res[g])
    );

    assign reload   = ctrl_q[g].cross_result ? lane_res[1-g] : lane_res[g];
    assign bus_res[g] = lane_res[g] |
                        (DATA_W'(ctrl_q[g].force_hi) << FORCE_POS);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q[g]  <= '0;
        base_q[g] <= '0;
        ctrl_q[g] <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(int'(A_ACC0) + g))
          acc_q[g] <= wr_data;
        else if (pop_fire)
          acc_q[g] <= reload;
        if (wr_en && wr_addr == ADDR_W'(int'(A_BASE0) + g))
          base_q[g] <= wr_data;
        if (wr_en && wr_addr == ADDR_W'(int'(A_CTRL0) + g))
          ctrl_q[g] <= wr_data[CTRL_W-1:0];
      end
    end
  end

  assign full_res = base_q[0] + base_q[1] + lane_win[0];

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        A_ACC0:           rd_data = acc_q[0];
        A_ACC1:           rd_data = acc_q[1];
        A_BASE0:          rd_data = base_q[0];
        A_BASE1:          rd_data = base_q[1];
        A_CTRL0:          rd_data = DATA_W'(ctrl_q[0]);
        A_CTRL1:          rd_data = DATA_W'(ctrl_q[1]);
        A_PEEK0, A_POP0:  rd_data = bus_res[0];
        A_PEEK1, A_POP1:  rd_data = bus_res[1];
        A_PEEKF, A_POPF:  rd_data = full_res;
        default:          rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/interp_dual_chk.sv
module interp_dual_chk
  import interp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] acc0,
  input logic [DATA_W-1:0] acc1,
  input logic [DATA_W-1:0] res0,
  input logic [DATA_W-1:0] res1,
  input lane_ctrl_t        ctrl0,
  input lane_ctrl_t        ctrl1
);
  logic is_peek, is_pop;
  assign is_peek = rd_en && (rd_addr == A_PEEK0 || rd_addr == A_PEEK1 || rd_addr == A_PEEKF);
  assign is_pop  = rd_en && (rd_addr == A_POP0 || rd_addr == A_POP1 || rd_addr == A_POPF);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc0 == '0 && acc1 == '0 && ctrl0 == '0 && ctrl1 == '0));

  a_r2_acc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ACC0) |=> (acc0 == $past(wr_data)));

  a_r10_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (is_peek && !wr_en) |=> (acc0 == $past(acc0) && acc1 == $past(acc1)));

  a_r11_pop_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pop && !wr_en) |=>
      (acc0 == $past(ctrl0.cross_result ? res1 : res0) &&
       acc1 == $past(ctrl1.cross_result ? res0 : res1)));

  a_r9_force_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_PEEK1) |-> ((rd_data[29:28] & ctrl1.force_hi) == ctrl1.force_hi));
endmodule

bind interp_dual interp_dual_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .acc0    (acc_q[0]),
  .acc1    (acc_q[1]),
  .res0    (lane_res[0]),
  .res1    (lane_res[1]),
  .ctrl0   (ctrl_q[0]),
  .ctrl1   (ctrl_q[1])
);

// File: tb/interp_dual_bench.sv
`timescale 1ns/1ps
module interp_dual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_acc [2];
  logic [31:0] m_base[2];
  logic [20:0] m_ctrl[2];

  always #2.5 clk = ~clk;

  interp_dual u_interp_dual (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [20:0] mk_ctrl(int rot, int lo, int hi, bit sg, bit ci,
                                          bit cr, bit ar, int fm);
    logic [20:0] c;
    c = '0;
    c[4:0] = rot[4:0]; c[9:5] = lo[4:0]; c[14:10] = hi[4:0];
    c[15] = sg; c[16] = ci; c[17] = cr; c[18] = ar; c[20:19] = fm[1:0];
    return c;
  endfunction

  function automatic logic [31:0] ref_window(logic [31:0] s, logic [20:0] c);
    logic [31:0] r, w;
    int sh, lo, hi;
    sh = int'(c[4:0]); lo = int'(c[9:5]); hi = int'(c[14:10]);
    for (int i = 0; i < 32; i++) r[i] = s[(i + sh) % 32];
    w = '0;
    for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) w[i] = r[i];
    if (c[15] && hi >= lo && w[hi])
      for (int i = 0; i < 32; i++) if (i > hi) w[i] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] ref_src(int l);
    return m_ctrl[l][16] ? m_acc[1-l] : m_acc[l];
  endfunction

  function automatic logic [31:0] ref_res(int l);
    return m_base[l] + (m_ctrl[l][18] ? ref_src(l) : ref_window(ref_src(l), m_ctrl[l]));
  endfunction

  function automatic logic [31:0] ref_read(logic [3:0] a);
    case (a)
      4'd0, 4'd1: return m_acc[a];
      4'd2, 4'd3: return m_base[a-2];
      4'd4, 4'd5: return {11'd0, m_ctrl[a-4]};
      4'd6, 4'd9: return ref_res(0) | {2'b00, m_ctrl[0][20:19], 28'd0};
      4'd7, 4'd10: return ref_res(1) | {2'b00, m_ctrl[1][20:19], 28'd0};
      4'd8, 4'd11: return m_base[0] + m_base[1] + ref_window(ref_src(0), m_ctrl[0]);
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    case (a)
      4'd0, 4'd1: m_acc[a] = d;
      4'd2, 4'd3: m_base[a-2] = d;
      4'd4, 4'd5: m_ctrl[a-4] = d[20:0];
      default: ;
    endcase
    #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, string tag);
    logic [31:0] n0, n1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = a;
    #1 chk(tag, rd_data, ref_read(a));
    n0 = m_ctrl[0][17] ? ref_res(1) : ref_res(0);
    n1 = m_ctrl[1][17] ? ref_res(0) : ref_res(1);
    @(posedge clk);
    if (a >= 4'd9 && a <= 4'd11) begin m_acc[0] = n0; m_acc[1] = n1; end
    #1 rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int l = 0; l < 2; l++) begin m_acc[l] = '0; m_base[l] = '0; m_ctrl[l] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state at every address
    for (int a = 0; a < 12; a++) bus_rd(4'(a), "R1 reset read");

    // R2: control word keeps 21 bits
    bus_wr(4'd4, 32'hFFFF_FFFF);
    bus_rd(4'd4, "R2 ctrl readback");
    bus_wr(4'd4, 32'd0);
    bus_wr(4'd3, 32'hCAFE_0001);
    bus_rd(4'd3, "R2 base readback");

    // R3: rotate right 8, keep 7:0 -> 0x56
    bus_wr(4'd0, 32'h1234_5678);
    bus_wr(4'd2, 32'd0);
    bus_wr(4'd4, {11'd0, mk_ctrl(8, 0, 7, 0, 0, 0, 0, 0)});
    bus_rd(4'd6, "R3 rotate window");
    chk("R3 literal", ref_read(4'd6), 32'h56);
    // R3: rotate right 28 and keep 31:4 is a left shift by 4
    bus_wr(4'd4, {11'd0, mk_ctrl(28, 4, 31, 0, 0, 0, 0, 0)});
    bus_rd(4'd6, "R3 left shift");

    // R4: empty window
    bus_wr(4'd2, 32'h0000_0100);
    bus_wr(4'd4, {11'd0, mk_ctrl(0, 10, 3, 1, 0, 0, 0, 0)});
    bus_rd(4'd6, "R4 empty window");

    // R5: sign extension from bit 7
    bus_wr(4'd0, 32'h0000_0080);
    bus_wr(4'd2, 32'd1);
    bus_wr(4'd4, {11'd0, mk_ctrl(0, 0, 7, 1, 0, 0, 0, 0)});
    bus_rd(4'd6, "R5 sign extend");
    chk("R5 literal", ref_read(4'd6), 32'hFFFF_FF81);

    // R6/R7: lane 1 cross-input with raw-add
    bus_wr(4'd1, 32'h0BAD_0000);
    bus_wr(4'd0, 32'h0000_1234);
    bus_wr(4'd5, {11'd0, mk_ctrl(4, 0, 3, 0, 1, 0, 1, 0)});
    bus_rd(4'd7, "R6 cross input under raw add");
    // R7: lane 0 raw add, combined result unaffected (R8)
    bus_wr(4'd4, {11'd0, mk_ctrl(4, 0, 7, 0, 0, 0, 1, 0)});
    bus_rd(4'd6, "R7 raw add");
    bus_rd(4'd8, "R8 combined ignores raw add");

    // R9: force pattern on bus only
    bus_wr(4'd4, {11'd0, mk_ctrl(0, 0, 15, 0, 0, 0, 0, 3)});
    bus_rd(4'd6, "R9 force on peek");
    bus_rd(4'd8, "R9 combined without force");
    bus_rd(4'd9, "R9 force on pop");
    bus_rd(4'd0, "R9 writeback without force");

    // R10: peek leaves accumulators
    bus_rd(4'd7, "R10 peek");
    bus_rd(4'd8, "R10 peek combined");
    bus_rd(4'd0, "R10 acc0 after peek");
    bus_rd(4'd1, "R10 acc1 after peek");

    // R11: pop with cross-result on lane 1
    bus_wr(4'd5, {11'd0, mk_ctrl(0, 0, 31, 0, 0, 1, 0, 0)});
    bus_rd(4'd11, "R11 pop combined");
    bus_rd(4'd0, "R11 acc0 after pop");
    bus_rd(4'd1, "R11 acc1 after cross pop");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0)
        bus_wr(4'($urandom % 6), $urandom);
      else
        bus_rd(4'($urandom % 12), "R3 R5 R6 R7 R8 R11 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule